// File: doc/BRIEF.md
# Disk Interface Status Register

This block is a read-only status byte on the host bus of a floppy disk controller. It reports the live state of the controller's disk-side outputs: the two motor enables, the write gate, and drive select 0 from the digital output register. Those levels are captured on the system clock. The byte also carries two toggle bits. Each toggle bit flips once for every return to the inactive level of the serial read-data line or of the serial write-data line.

A host read at I/O offset 0x3F1 puts the byte on the data bus only when the controller runs in PS/2-compatible mode. In AT-compatible mode the bus is left floating for that read. A hardware reset (asynchronous, active low) clears all state. A software reset leaves every bit untouched.

Top module: `fdc_sts_top`

## Requirements
- R1: `data_oe_o` is 1 exactly when `rd_i` is 1, `addr_i` equals 0x3F1 and `ps2_mode_i` is 1. Any other address keeps it at 0.
- R2: With `ps2_mode_i` at 0 (AT-compatible), a read of 0x3F1 leaves `data_oe_o` at 0.
- R3: Bit 0 shows `mot_en0_i` and bit 1 shows `mot_en1_i`, each one clock after the input changes.
- R4: Bit 2 shows `wgate_i`, one clock after the input changes.
- R5: Bit 3 inverts once for each low-to-high transition of the active-low `rdata_ni`. The inversion appears within three clocks of the transition. A high-to-low transition leaves the bit unchanged.
- R6: Bit 4 inverts once for each low-to-high transition of the active-low `wdata_ni`, with the same timing as R5.
- R7: Bit 5 shows `dor_ds0_i`, one clock after the input changes.
- R8: Bits 7 and 6 always read as 1.
- R9: After a hardware reset the byte reads 0xC0.
- R10: Asserting `soft_rst_i` changes no bit of the byte.
- R11: A write strobe `wr_i` to 0x3F1 changes no bit of the byte.
- R12: `data_o` is 0x00 whenever `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Hardware reset, asynchronous, active low |
| soft_rst_i | input | 1 | Software reset pulse (no effect on this byte) |
| ps2_mode_i | input | 1 | 1 = PS/2-compatible, 0 = AT-compatible |
| addr_i | input | 10 | Host I/O address |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Data bus drive enable |
| mot_en0_i | input | 1 | Motor enable 0 output level |
| mot_en1_i | input | 1 | Motor enable 1 output level |
| wgate_i | input | 1 | Write gate output level |
| dor_ds0_i | input | 1 | Drive select 0 bit of the digital output register |
| rdata_ni | input | 1 | Serial read data, active low, asynchronous |
| wdata_ni | input | 1 | Serial write data, active low, asynchronous |

## Verification
A toggle bit with a wrong internal value stays wrong at every later read. It only reverses polarity at the next edge, so one read after an odd number of pulses exposes a missed or doubled edge. A captured pin bit with a wrong value shows up on the first read one clock after the input settles. A fault in the decode or the mode gating shows up at once on `data_oe_o`, in the same cycle as the strobe.

// File: rtl/fdc_sts_pkg.sv
package fdc_sts_pkg;
  parameter int unsigned ADDR_W   = 10;
  parameter logic [ADDR_W-1:0] STS_ADDR = 10'h3F1;

  // bit order is the host-visible layout
  typedef struct packed {
    logic [1:0] rsvd;
    logic       ds0;
    logic       wd_tog;
    logic       rd_tog;
    logic       wgate;
    logic       mot1;
    logic       mot0;
  } sts_reg_t;

  localparam int unsigned STS_W = $bits(sts_reg_t);
endpackage

// File: rtl/fdc_sts_edge.sv
module fdc_sts_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic rise_o,
  output logic toggle_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          tog_q;

  // idle level of the active-low line is 1: reset there so no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[LAST-1:0], pin_ni};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else if (rise_o) tog_q <= ~tog_q;
  end

  assign toggle_o = tog_q;

  assert_tog_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (tog_q != $past(tog_q)));
  assert_tog_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_o |=> $stable(tog_q));
endmodule

// File: rtl/fdc_sts_rdport.sv
module fdc_sts_rdport
  import fdc_sts_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              ps2_mode_i,
  input  sts_reg_t          reg_i,
  output logic [STS_W-1:0]  data_o,
  output logic              oe_o
);
  logic hit;

  assign hit    = rd_i && (addr_i == STS_ADDR);
  assign oe_o   = hit && ps2_mode_i;
  assign data_o = oe_o ? reg_i : '0;
endmodule

// File: rtl/fdc_sts_top.sv
module fdc_sts_top
  import fdc_sts_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              ps2_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [STS_W-1:0]  data_o,
  output logic              data_oe_o,
  input  logic              mot_en0_i,
  input  logic              mot_en1_i,
  input  logic              wgate_i,
  input  logic              dor_ds0_i,
  input  logic              rdata_ni,
  input  logic              wdata_ni
);
  sts_reg_t sts;
  logic     pins_q_mot0, pins_q_mot1, pins_q_wg, pins_q_ds0;
  logic     rd_tog, wd_tog, rd_rise, wd_rise;
  logic     live_q;

  // pin levels captured; only hardware reset clears them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q_mot0 <= 1'b0;
      pins_q_mot1 <= 1'b0;
      pins_q_wg   <= 1'b0;
      pins_q_ds0  <= 1'b0;
      live_q      <= 1'b0;
    end else begin
      pins_q_mot0 <= mot_en0_i;
      pins_q_mot1 <= mot_en1_i;
      pins_q_wg   <= wgate_i;
      pins_q_ds0  <= dor_ds0_i;
      live_q      <= 1'b1;
    end
  end

  fdc_sts_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rd_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(rdata_ni),
    .rise_o(rd_rise), .toggle_o(rd_tog));

  fdc_sts_edge #(.SYNC_STAGES(SYNC_STAGES)) u_wd_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(wdata_ni),
    .rise_o(wd_rise), .toggle_o(wd_tog));

  always_comb begin
    sts.rsvd   = 2'b11;
    sts.ds0    = pins_q_ds0;
    sts.wd_tog = wd_tog;
    sts.rd_tog = rd_tog;
    sts.wgate  = pins_q_wg;
    sts.mot1   = pins_q_mot1;
    sts.mot0   = pins_q_mot0;
  end

  fdc_sts_rdport u_rdport (
    .addr_i(addr_i), .rd_i(rd_i), .ps2_mode_i(ps2_mode_i),
    .reg_i(sts), .data_o(data_o), .oe_o(data_oe_o));

  assert_oe_decode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (rd_i && addr_i == STS_ADDR));
  assert_at_float_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ps2_mode_i |-> !data_oe_o);
  assert_mot0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && data_oe_o) |-> data_o[0] == $past(mot_en0_i));
  assert_ds0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && data_oe_o) |-> data_o[5] == $past(dor_ds0_i));
  assert_rsvd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> data_o[7:6] == 2'b11);
  assert_soft_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !rd_rise && !wd_rise) |=> ($stable(rd_tog) && $stable(wd_tog)));
  assert_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_rise && !wd_rise) |=> ($stable(rd_tog) && $stable(wd_tog)));
  assert_idle_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
endmodule

// File: tb/fdc_sts_top_tb_top.sv
module fdc_sts_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0, ps2_mode_i = 1'b1;
  logic [9:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic       mot_en0_i = 1'b0, mot_en1_i = 1'b0, wgate_i = 1'b0, dor_ds0_i = 1'b0;
  logic       rdata_ni = 1'b1, wdata_ni = 1'b1;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rt = 1'b0, wt = 1'b0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  fdc_sts_top dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model();
    return {2'b11, dor_ds0_i, wt, rt, wgate_i, mot_en1_i, mot_en0_i};
  endfunction

  // driver: push expectation, then issue one read cycle at 0x3F1
  task automatic rd_expect(input string tag);
    @(negedge clk_i);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    addr_i = 10'h3F1; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic settle(); repeat (6) @(negedge clk_i); endtask

  task automatic pulse(input bit on_rd);
    @(negedge clk_i);
    if (on_rd) rdata_ni = 1'b0; else wdata_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    if (on_rd) rdata_ni = 1'b1; else wdata_ni = 1'b1;
    if (on_rd) rt = ~rt; else wt = ~wt;
    settle();
  endtask

  // monitor: compare each driven byte as it appears
  always @(posedge clk_i) begin
    #2;
    if (data_oe_o) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected drive", data_o, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(data_o == e, t, data_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(data_oe_o == 1'b0 && data_o == 8'h00, "R12 reset idle", data_o, 0);
    rst_ni = 1'b1;
    rd_expect("R9 reset value 0xC0");
    settle();

    // R3 R4 R7 pin capture, several patterns
    mot_en0_i = 1; settle(); rd_expect("R3 mot0");
    mot_en1_i = 1; mot_en0_i = 0; settle(); rd_expect("R3 mot1");
    wgate_i = 1; settle(); rd_expect("R4 wgate");
    dor_ds0_i = 1; wgate_i = 0; settle(); rd_expect("R7 ds0");
    mot_en0_i = 1; wgate_i = 1; settle(); rd_expect("R8 all pins set, reserved");

    // R5 R6 toggles
    pulse(1'b1); rd_expect("R5 rd toggle 1");
    pulse(1'b1); rd_expect("R5 rd toggle 2");
    pulse(1'b0); rd_expect("R6 wd toggle 1");
    pulse(1'b1); pulse(1'b0); pulse(1'b0); rd_expect("R6 mixed toggles");
    // falling edge alone does not flip
    @(negedge clk_i); rdata_ni = 1'b0; settle(); rd_expect("R5 falling edge ignored");
    rdata_ni = 1'b1; rt = ~rt; settle(); rd_expect("R5 rise after long low");

    // R10 soft reset
    @(negedge clk_i); soft_rst_i = 1; @(negedge clk_i); soft_rst_i = 0;
    settle(); rd_expect("R10 soft reset no effect");

    // R11 write strobe
    @(negedge clk_i); addr_i = 10'h3F1; wr_i = 1; @(negedge clk_i); wr_i = 0;
    settle(); rd_expect("R11 write ignored");

    // R1 wrong address
    @(negedge clk_i); addr_i = 10'h3F2; rd_i = 1; #1;
    check(data_oe_o == 0, "R1 other address", data_oe_o, 0);
    check(data_o == 8'h00, "R12 data zero when idle", data_o, 0);
    @(negedge clk_i); rd_i = 0;

    // R2 AT mode
    ps2_mode_i = 0;
    @(negedge clk_i); addr_i = 10'h3F1; rd_i = 1; #1;
    check(data_oe_o == 0, "R2 AT mode float", data_oe_o, 0);
    @(negedge clk_i); rd_i = 0; ps2_mode_i = 1;

    // hardware reset mid-run
    @(negedge clk_i); rst_ni = 0; mot_en0_i = 0; mot_en1_i = 0; wgate_i = 0; dor_ds0_i = 0;
    rt = 0; wt = 0;
    @(negedge clk_i); rst_ni = 1;
    rd_expect("R9 value after second reset");

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R1 all reads driven", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule